// File: doc/BRIEF.md
# Serial Command Register Loader

This block sits on a two-wire asynchronous serial link, with one receive line and one transmit line and no flow control. It turns short typed commands into writes to a small bank of configuration registers. A line holds four hexadecimal characters followed by a carriage return. The first two characters select a register and the last two give the byte to store. Every register is available at all times on a wide parallel output, so the logic around the block can read its settings directly.

The block includes the bit-level receiver and transmitter. It answers every carriage return with a two-byte reply. A successful write returns `K`, and a rejected line returns `?`. An operator at a terminal, or a simple host script, therefore knows whether each line was accepted. Line feeds are skipped, so the host may end its lines with either CR or CR-LF. The register count, register width, oversampling ratio and clock divider are all parameters.

Top module: `cfg_serial_loader`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) every register reads 0x00 and `txd` idles at 1.
- R2: Characters are framed as one start bit (0), 8 data bits sent LSB first and one stop bit (1), with no parity. One bit lasts OVERSAMPLE*TICK_DIV clocks. The start bit is confirmed at its middle, so a low pulse shorter than half a bit produces no character.
- R3: Four hex characters followed by CR (0x0D) write one register in a single clock cycle. The first two characters are the register index and the last two are the value. The write takes effect during the stop bit of the CR, and a later write to the same index replaces the earlier value.
- R4: The characters 0-9, a-f and A-F are all accepted as hex digits.
- R5: A valid line is answered with 'K' (0x4B) followed by CR (0x0D).
- R6: A line that contains any character other than a hex digit or LF is rejected: no register changes and the answer is '?' (0x3F) followed by CR.
- R7: A line with fewer or more than four hex digits, including an empty line, is rejected with no write and the answer '?' CR.
- R8: A line whose index is NUM_REGS (0x10) or more is rejected with no write and the answer '?' CR.
- R9: LF (0x0A) is ignored wherever it appears. It does not count as a digit and does not make a line invalid.
- R10: A character whose stop bit reads 0 is dropped and has no effect on the line being assembled.
- R11: Registers change only when a valid line is written, and a write changes only the register it selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| cfg_regs | output | NUM_REGS*REG_W | All registers side by side; register i is at bits [i*REG_W +: REG_W] |

## Verification
The hardest cases to reach from the pins are faults on the wire itself: a short low glitch that must not start a character, and a character with a bad stop bit that must vanish without disturbing the line being assembled. The bench drives these waveforms directly on `rxd`. It places the bad character in the middle of a line. If the bad character were kept, the line would hold five digits and be rejected; if it is dropped, the line holds four digits and gives `K`. The glitch is followed by a normal command, and any stray character would turn that command's reply into `?` or add extra reply bytes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   localparam int        CHAR_W = 8;
   localparam logic [7:0] CH_CR  = 8'h0D;
   localparam logic [7:0] CH_LF  = 8'h0A;
   localparam logic [7:0] CH_ACK = 8'h4B;
   localparam logic [7:0] CH_NAK = 8'h3F;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
   typedef enum logic [1:0] {RS_IDLE, RS_CODE, RS_EOL} resp_state_t;

   // bit 4 flags a hex digit, bits 3:0 carry its value
   function automatic logic [4:0] hex_val(input logic [7:0] c);
      if (c >= 8'h30 && c <= 8'h39) return {1'b1, 4'(c - 8'h30)};
      if (c >= 8'h61 && c <= 8'h66) return {1'b1, 4'(c - 8'h57)};
      if (c >= 8'h41 && c <= 8'h46) return {1'b1, 4'(c - 8'h37)};
      return 5'b0;
   endfunction
endpackage

// File: rtl/cfgld_uart_rx.sv
module cfgld_uart_rx
   import cfgld_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              os_tick,
   input  logic              rxd,
   output logic              byte_vld,
   output logic [CHAR_W-1:0] byte_out
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(CHAR_W + 1);

   logic [1:0]        sync;
   logic              line;
   rx_state_t         st;
   logic [CW-1:0]     tcnt;
   logic [BW-1:0]     bcnt;
   logic [CHAR_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) sync <= 2'b11;
      else     sync <= {sync[0], rxd};
   end
   assign line = sync[1];

   always_ff @(posedge clk) begin
      byte_vld <= 1'b0;
      if (rst) begin
         st    <= RX_IDLE;
         tcnt  <= '0;
         bcnt  <= '0;
         shreg <= '0;
      end else begin
         case (st)
            RX_IDLE: if (!line) begin
               st   <= RX_START;
               tcnt <= '0;
            end
            RX_START: if (os_tick) begin
               if (tcnt == CW'(OVS/2 - 1)) begin
                  tcnt <= '0;
                  bcnt <= '0;
                  st   <= line ? RX_IDLE : RX_DATA;
               end else tcnt <= tcnt + 1'b1;
            end
            RX_DATA: if (os_tick) begin
               if (tcnt == CW'(OVS - 1)) begin
                  tcnt  <= '0;
                  shreg <= {line, shreg[CHAR_W-1:1]};
                  bcnt  <= bcnt + 1'b1;
                  if (bcnt == BW'(CHAR_W - 1)) st <= RX_STOP;
               end else tcnt <= tcnt + 1'b1;
            end
            default: if (os_tick) begin
               if (tcnt == CW'(OVS - 1)) begin
                  tcnt     <= '0;
                  st       <= RX_IDLE;
                  byte_vld <= line;
               end else tcnt <= tcnt + 1'b1;
            end
         endcase
      end
   end
   assign byte_out = shreg;
endmodule

// File: rtl/cfgld_uart_tx.sv
module cfgld_uart_tx
   import cfgld_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              os_tick,
   input  logic              start,
   input  logic [CHAR_W-1:0] din,
   output logic              busy,
   output logic              txd
);
   localparam int FW = CHAR_W + 2;
   localparam int CW = $clog2(OVS);
   localparam int NW = $clog2(FW + 1);

   logic [FW-1:0] frame;
   logic [NW-1:0] left;
   logic [CW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         frame <= '1;
         left  <= '0;
         tcnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            frame <= {1'b1, din, 1'b0};
            left  <= NW'(FW);
            tcnt  <= '0;
            busy  <= 1'b1;
         end
      end else if (os_tick) begin
         if (tcnt == CW'(OVS - 1)) begin
            tcnt  <= '0;
            frame <= {1'b1, frame[FW-1:1]};
            left  <= left - 1'b1;
            if (left == NW'(1)) busy <= 1'b0;
         end else tcnt <= tcnt + 1'b1;
      end
   end
   assign txd = frame[0];
endmodule

// File: rtl/cfgld_parser.sv
module cfgld_parser
   import cfgld_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int NREG     = 16,
   parameter int ADDR_DIG = 2,
   parameter int AW       = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_vld,
   input  logic [CHAR_W-1:0] byte_in,
   input  logic              tx_busy,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [REG_W-1:0]  wr_data,
   output logic              tx_start,
   output logic [CHAR_W-1:0] tx_byte
);
   localparam int AF   = 4 * ADDR_DIG;
   localparam int NDIG = ADDR_DIG + REG_W / 4;
   localparam int ACCW = AF + REG_W;
   localparam int DCW  = $clog2(NDIG + 2);

   logic [ACCW-1:0] acc;
   logic [DCW-1:0]  ndig;
   logic            bad;
   logic [4:0]      hv;
   logic            is_cr, is_lf, line_ok;
   logic [AF-1:0]   a_fld;
   resp_state_t     rs;
   logic [CHAR_W-1:0] code;
   logic            sent_q;

   assign hv      = hex_val(byte_in);
   assign is_cr   = (byte_in == CH_CR);
   assign is_lf   = (byte_in == CH_LF);
   assign a_fld   = acc[ACCW-1:REG_W];
   assign line_ok = !bad && (ndig == DCW'(NDIG)) && ({1'b0, a_fld} < (AF+1)'(NREG));
   assign wr_en   = byte_vld && is_cr && line_ok;
   assign wr_addr = a_fld[AW-1:0];
   assign wr_data = acc[REG_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc  <= '0;
         ndig <= '0;
         bad  <= 1'b0;
      end else if (byte_vld) begin
         if (is_cr) begin
            acc  <= '0;
            ndig <= '0;
            bad  <= 1'b0;
         end else if (hv[4]) begin
            acc <= {acc[ACCW-5:0], hv[3:0]};
            if (ndig != DCW'(NDIG + 1)) ndig <= ndig + 1'b1;
         end else if (!is_lf) begin
            bad <= 1'b1;
         end
      end
   end

   // two-byte reply; sent_q covers the cycle before the transmitter shows busy
   always_comb begin
      tx_start = (rs != RS_IDLE) && !tx_busy && !sent_q;
      tx_byte  = (rs == RS_CODE) ? code : CH_CR;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rs     <= RS_IDLE;
         code   <= CH_NAK;
         sent_q <= 1'b0;
      end else begin
         sent_q <= tx_start;
         case (rs)
            RS_IDLE: if (byte_vld && is_cr) begin
               code <= line_ok ? CH_ACK : CH_NAK;
               rs   <= RS_CODE;
            end
            RS_CODE: if (tx_start) rs <= RS_EOL;
            default: if (tx_start) rs <= RS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfgld_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int NUM_REGS    = 16,
   parameter int ADDR_DIGITS = 2,
   parameter int OVERSAMPLE  = 16,
   parameter int TICK_DIV    = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      rxd,
   output logic                      txd,
   output logic [NUM_REGS*REG_W-1:0] cfg_regs
);
   localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (REG_W % 4 != 0 || REG_W < 4) begin : g_bad_width
      $error("REG_W must be a positive multiple of 4");
   end
   if (OVERSAMPLE < 4 || OVERSAMPLE % 2 != 0) begin : g_bad_ovs
      $error("OVERSAMPLE must be even and at least 4");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (NUM_REGS < 1 || AW > 4 * ADDR_DIGITS) begin : g_bad_regs
      $error("NUM_REGS does not fit the index digits");
   end

   logic              os_tick;
   logic              rx_vld;
   logic [CHAR_W-1:0] rx_byte;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [REG_W-1:0]  wr_data;
   logic              tx_start, tx_busy;
   logic [CHAR_W-1:0] tx_byte;

   if (TICK_DIV == 1) begin : g_tick_full
      assign os_tick = 1'b1;
   end else begin : g_tick_div
      localparam int TW = $clog2(TICK_DIV);
      logic [TW-1:0] tc;
      always_ff @(posedge clk) begin
         if (rst || tc == TW'(TICK_DIV - 1)) tc <= '0;
         else                                tc <= tc + 1'b1;
      end
      assign os_tick = (tc == TW'(TICK_DIV - 1));
   end

   cfgld_uart_rx #(.OVS(OVERSAMPLE)) u_rx (
      .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
      .byte_vld(rx_vld), .byte_out(rx_byte)
   );

   cfgld_parser #(.REG_W(REG_W), .NREG(NUM_REGS), .ADDR_DIG(ADDR_DIGITS), .AW(AW)) u_parse (
      .clk(clk), .rst(rst), .byte_vld(rx_vld), .byte_in(rx_byte), .tx_busy(tx_busy),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tx_start(tx_start), .tx_byte(tx_byte)
   );

   cfgld_uart_tx #(.OVS(OVERSAMPLE)) u_tx (
      .clk(clk), .rst(rst), .os_tick(os_tick), .start(tx_start), .din(tx_byte),
      .busy(tx_busy), .txd(txd)
   );

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)                                q <= '0;
         else if (wr_en && wr_addr == AW'(g))    q <= wr_data;
      end
      assign cfg_regs[g*REG_W +: REG_W] = q;
   end
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int W = 128
) (
   input logic         clk,
   input logic         rst,
   input logic         txd,
   input logic [W-1:0] cfg_regs,
   input logic         byte_vld,
   input logic [7:0]   byte_in,
   input logic         wr_en,
   input logic         tx_busy
);
   // writes happen only on the cycle a CR arrives
   p_write_on_eol_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (byte_vld && byte_in == 8'h0D));

   // registers hold unless a write was issued
   p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(cfg_regs));

   // received characters arrive as single-cycle strobes
   p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      byte_vld |=> !byte_vld);

   // a line feed never triggers a write
   p_lf_no_write_r9: assert property (@(posedge clk) disable iff (rst)
      (byte_vld && byte_in == 8'h0A) |-> !wr_en);

   // the transmit line idles high whenever nothing is being sent
   p_tx_idle_mark_r5: assert property (@(posedge clk) disable iff (rst)
      !tx_busy |-> txd);

   // registers are cleared on the first cycle after reset
   always @(posedge clk) begin
      if (!rst && $past(rst)) begin
         p_reset_clear_r1: assert (cfg_regs == '0);
      end
   end
endmodule

bind cfg_serial_loader cfgld_chk #(.W(NUM_REGS*REG_W)) u_chk (
   .clk(clk), .rst(rst), .txd(txd), .cfg_regs(cfg_regs),
   .byte_vld(rx_vld), .byte_in(rx_byte), .wr_en(wr_en), .tx_busy(tx_busy)
);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
   localparam int NR  = 16;
   localparam int BIT = 16 * 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rxd = 1'b1;
   logic txd;
   logic [NR*8-1:0] cfg_regs;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;
   bit done   = 1'b0;

   logic [7:0] exp_regs [NR];
   logic [7:0] rxq [$];
   int  m_nd, m_acc;
   bit  m_bad;
   logic [7:0] exp_code;

   always #10 clk = ~clk;

   cfg_serial_loader i_cfg_serial_loader (
      .clk(clk), .rst(rst), .rxd(rxd), .txd(txd), .cfg_regs(cfg_regs)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference compare of every register on every clock while the model is settled (R11, R3)
   always @(negedge clk) begin
      if (cmp_en && !rst) begin
         for (int i = 0; i < NR; i++) begin
            checks++;
            if (cfg_regs[i*8 +: 8] !== exp_regs[i]) begin
               errors++;
               if (errors < 20)
                  $display("FAIL R11 reg %0d: actual=%0h expected=%0h",
                           i, cfg_regs[i*8 +: 8], exp_regs[i]);
            end
         end
      end
   end

   // behavioural serial receiver on txd
   initial begin
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            logic [7:0] b;
            repeat (BIT/2) @(negedge clk);
            if (txd === 1'b0) begin
               for (int i = 0; i < 8; i++) begin
                  repeat (BIT) @(negedge clk);
                  b[i] = txd;
               end
               repeat (BIT) @(negedge clk);
               rxq.push_back(txd === 1'b1 ? b : 8'hEE);
            end
         end
      end
   end

   function automatic int hexv(input logic [7:0] c);
      if (c >= 8'h30 && c <= 8'h39) return int'(c) - 48;
      if (c >= 8'h61 && c <= 8'h66) return int'(c) - 87;
      if (c >= 8'h41 && c <= 8'h46) return int'(c) - 55;
      return -1;
   endfunction

   function automatic void model_char(input logic [7:0] c);
      if (c == 8'h0D) begin
         int a = (m_acc >> 8) & 255;
         if (!m_bad && m_nd == 4 && a < NR) begin
            exp_regs[a] = 8'(m_acc & 255);
            exp_code = 8'h4B;
         end else exp_code = 8'h3F;
         m_nd = 0; m_acc = 0; m_bad = 0;
      end else if (c != 8'h0A) begin
         if (hexv(c) >= 0) begin
            m_nd++;
            m_acc = ((m_acc << 4) | hexv(c)) & 16'hFFFF;
         end else m_bad = 1;
      end
   endfunction

   task automatic put_byte(input logic [7:0] b, input bit bad_stop);
      @(posedge clk);
      rxd <= 1'b0;
      repeat (BIT) @(posedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd <= b[i];
         repeat (BIT) @(posedge clk);
      end
      rxd <= bad_stop ? 1'b0 : 1'b1;
      repeat (BIT) @(posedge clk);
      rxd <= 1'b1;
      if (bad_stop) repeat (2*BIT) @(posedge clk);
   endtask

   task automatic send_char(input logic [7:0] c, input bit bad_stop);
      if (c == 8'h0D) cmp_en = 1'b0;
      put_byte(c, bad_stop);
      if (!bad_stop) model_char(c);
      if (c == 8'h0D) cmp_en = 1'b1;
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send_char(s[i], 1'b0);
   endtask

   task automatic expect_reply(input string req);
      repeat (24*BIT) @(posedge clk);
      check(rxq.size() == 2, req, "reply length", rxq.size(), 2);
      if (rxq.size() == 2) begin
         check(rxq[0] == exp_code, req, "reply code", rxq[0], exp_code);
         check(rxq[1] == 8'h0D, req, "reply end", rxq[1], 8'h0D);
      end
      rxq.delete();
   endtask

   initial begin
      for (int i = 0; i < NR; i++) exp_regs[i] = 8'h00;
      m_nd = 0; m_acc = 0; m_bad = 0; exp_code = 8'h3F;
      repeat (5) @(posedge clk);
      rst <= 1'b0;
      @(negedge clk);
      // R1: reset state
      check(cfg_regs == '0, "R1", "regs after reset", int'(cfg_regs[31:0]), 0);
      check(txd === 1'b1, "R1", "txd idle", int'(txd), 1);
      cmp_en = 1'b1;

      send_str("0af8\015");      expect_reply("R3 R5 basic write");
      send_str("0B5C\015");      expect_reply("R4 upper case");
      send_str("03ab\015");      expect_reply("R4 lower case");
      send_str("0a01\015");      expect_reply("R3 overwrite");
      send_str("0f7e\015\012");  expect_reply("R9 CR-LF, top index");
      send_str("0\0125\0123c\015"); expect_reply("R9 LF inside line");
      send_str("0g12\015");      expect_reply("R6 bad character");
      send_str("01-2\015");      expect_reply("R6 punctuation");
      send_str("012\015");       expect_reply("R7 three digits");
      send_str("01234\015");     expect_reply("R7 five digits");
      send_str("\015");          expect_reply("R7 empty line");
      send_str("1012\015");      expect_reply("R8 index 0x10");
      send_str("ff00\015");      expect_reply("R8 index 0xff");

      // R10: middle character with a bad stop bit is dropped
      send_char(8'h30, 1'b0);
      send_char(8'h31, 1'b0);
      send_char(8'h39, 1'b1);
      send_char(8'h35, 1'b0);
      send_char(8'h35, 1'b0);
      send_char(8'h0D, 1'b0);
      expect_reply("R10 bad stop dropped");
      check(cfg_regs[1*8 +: 8] == 8'h55, "R10", "reg 1", int'(cfg_regs[15:8]), 8'h55);

      // R2: short low glitch on rxd yields no character
      @(posedge clk);
      rxd <= 1'b0;
      repeat (6) @(posedge clk);
      rxd <= 1'b1;
      repeat (2*BIT) @(posedge clk);
      check(rxq.size() == 0, "R2", "no reply after glitch", rxq.size(), 0);
      send_str("0233\015");      expect_reply("R2 command after glitch");
      check(cfg_regs[2*8 +: 8] == 8'h33, "R2", "reg 2", int'(cfg_regs[23:16]), 8'h33);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule